// File: doc/BRIEF.md
# SCL Phase Generator with Deglitch Compensation

This block produces the clock line of a two-wire serial bus master. It holds the clock low for a programmed number of cycles and then releases it for a programmed number of cycles. It emits four single-cycle phase strobes that a byte sequencer uses to place data: clock falling, data change point, clock released, and data sample point. The block runs from an 80 MHz system clock, so the bus frequency is 80 MHz divided by the total cycle count of one low and one released phase.

Both line inputs pass through a deglitch filter with its own enable and threshold. A filter with threshold T updates its output only after the raw line has shown a new level for more than T consecutive samples. The filter delays the point at which the block sees the released clock line. The released-phase count therefore starts only when the filtered clock reads high, and a fixed offset is added to the terminal count so that the total released time matches a fixed formula. A slave that holds the clock low stretches the released phase by exactly the time it holds it low. A park input keeps the clock pulled low and freezes the phase machine.

Top module: `scl_phase_gen`

## Requirements
- R1: The clock is pulled low (scl_drive_low = 1) for exactly lo_period + 1 consecutive cycles in each low phase.
- R2: With the clock filter disabled and no stretching, the clock is released for exactly hi_period + 7 cycles.
- R3: With the clock filter enabled and a threshold from 0 to 2, the released phase lasts exactly hi_period + 8 cycles when there is no stretching.
- R4: With the clock filter enabled and a threshold T from 3 to 7, the released phase lasts exactly hi_period + 6 + T cycles when there is no stretching.
- R5: The released-phase count starts only once the filtered clock reads high. If the line is held low for S cycles after release, the released phase becomes exactly S cycles longer than the R2 to R4 value.
- R6: An enabled filter with threshold T changes its output only after the raw input has differed from it for T + 1 consecutive samples. The output changes at the clock edge that takes the (T + 1)th sample, and shorter pulses leave it unchanged. A disabled filter copies its input one cycle later. Both polarities behave the same.
- R7: stb_fall fires exactly once per low phase, on its first cycle (index 0). stb_change fires exactly once, on low-phase cycle index hold_pos, where hold_pos must not exceed lo_period.
- R8: stb_rise fires exactly once per released phase, on its first cycle. stb_sample fires exactly once, sample_pos cycles after the first released cycle in which scl_filt reads high, where sample_pos must not exceed hi_period + 4.
- R9: While park is high, the clock is pulled low and no strobe fires. After park falls, the clock stays low for lo_period further clock edges before it is released.
- R10: During reset, the clock is pulled low and both filter outputs read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| park | input | 1 | Hold the clock low and freeze the phase machine |
| lo_period | input | PW | Low-phase count (low time = lo_period + 1) |
| hi_period | input | PW | Released-phase base count |
| hold_pos | input | PW | Low-phase cycle index of the data change strobe |
| sample_pos | input | PW+1 | Offset of the sample strobe from the first filtered-high cycle |
| scl_dg_en | input | 1 | Clock input filter enable |
| scl_dg_thr | input | TW | Clock input filter threshold |
| sda_dg_en | input | 1 | Data input filter enable |
| sda_dg_thr | input | TW | Data input filter threshold |
| scl_in | input | 1 | Raw sampled clock line |
| sda_in | input | 1 | Raw sampled data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |
| stb_fall | output | 1 | First cycle of a low phase |
| stb_change | output | 1 | Data change point within the low phase |
| stb_rise | output | 1 | First cycle of a released phase |
| stb_sample | output | 1 | Data sample point within the released phase |

## Verification
The bench measures full low and released phases for every threshold value with the filter enabled, and with it disabled. A design that took the filter delay out of the terminal count, or applied the wrong threshold range, would produce a released phase that is off by a few cycles. Stretched phases, with the line held low for up to a few dozen cycles, expose a counter that starts at release rather than at the filtered high: the extra length would fall short of the stretch. Filter pulses at exactly the threshold width and one cycle longer, in both polarities, catch an off-by-one in the deglitch comparison. A park released mid-phase catches a machine that resumes its old count instead of restarting the low phase.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int PW = 8,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          park,
  input  logic [PW-1:0] lo_period,
  input  logic [PW-1:0] hi_period,
  input  logic [PW-1:0] hold_pos,
  input  logic [PW:0]   sample_pos,
  input  logic          scl_dg_en,
  input  logic [TW-1:0] scl_dg_thr,
  input  logic          sda_dg_en,
  input  logic [TW-1:0] sda_dg_thr,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          scl_filt,
  output logic          sda_filt,
  output logic          stb_fall,
  output logic          stb_change,
  output logic          stb_rise,
  output logic          stb_sample
);

  localparam int CW = PW + 1;

  typedef enum logic [1:0] {PH_LOW, PH_WAIT, PH_HIGH} phase_t;

  logic [1:0]         raw_v, en_v, flt_v;
  logic [1:0][TW-1:0] thr_v;

  assign raw_v = {sda_in, scl_in};
  assign en_v  = {sda_dg_en, scl_dg_en};
  assign thr_v = {sda_dg_thr, scl_dg_thr};

  for (genvar g = 0; g < 2; g++) begin : g_dg
    logic          q;
    logic [TW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q   <= 1'b1;
        run <= '0;
      end else if (raw_v[g] == q) begin
        run <= '0;
      end else if (!en_v[g] || run == thr_v[g]) begin
        q   <= raw_v[g];
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
    assign flt_v[g] = q;
  end

  assign scl_filt = flt_v[0];
  assign sda_filt = flt_v[1];

  phase_t        ph;
  logic [CW-1:0] cnt, hi_top;

  always_comb begin
    if (!scl_dg_en)
      hi_top = CW'(hi_period) + CW'(5);
    else if (scl_dg_thr <= TW'(2))
      hi_top = CW'(hi_period) + CW'(6) - CW'(scl_dg_thr);
    else
      hi_top = CW'(hi_period) + CW'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_LOW;
      cnt <= '0;
    end else if (park) begin
      ph  <= PH_LOW;
      cnt <= '0;
    end else begin
      case (ph)
        PH_LOW: begin
          if (cnt == CW'(lo_period)) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAIT: begin
          if (scl_filt) begin
            ph  <= PH_HIGH;
            cnt <= CW'(1);
          end else if (!(&cnt)) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == hi_top) begin
            ph  <= PH_LOW;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ph  <= PH_LOW;
          cnt <= '0;
        end
      endcase
    end
  end

  wire live = !park;

  assign scl_drive_low = park || (ph == PH_LOW);
  assign stb_fall      = live && ph == PH_LOW && cnt == '0;
  assign stb_change    = live && ph == PH_LOW && cnt == CW'(hold_pos);
  assign stb_rise      = live && ph == PH_WAIT && cnt == '0;
  assign stb_sample    = live && ((ph == PH_WAIT && scl_filt && sample_pos == '0) ||
                                  (ph == PH_HIGH && cnt == sample_pos));

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic park,
  input logic scl_in,
  input logic sda_in,
  input logic scl_drive_low,
  input logic scl_filt,
  input logic sda_filt,
  input logic stb_fall,
  input logic stb_change,
  input logic stb_rise,
  input logic stb_sample
);

  p_fall_on_low_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_drive_low) && !park) |-> stb_fall);

  p_change_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_change |-> scl_drive_low);

  p_rise_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> stb_rise);

  p_sample_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_sample |-> !scl_drive_low);

  p_park_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    park |-> (scl_drive_low && !stb_fall && !stb_change && !stb_rise && !stb_sample));

  p_unpark_stays_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(park) |-> scl_drive_low);

  p_scl_flt_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_filt) |-> (scl_filt == $past(scl_in)));

  p_sda_flt_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_filt) |-> (sda_filt == $past(sda_in)));

endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .park         (park),
  .scl_in       (scl_in),
  .sda_in       (sda_in),
  .scl_drive_low(scl_drive_low),
  .scl_filt     (scl_filt),
  .sda_filt     (sda_filt),
  .stb_fall     (stb_fall),
  .stb_change   (stb_change),
  .stb_rise     (stb_rise),
  .stb_sample   (stb_sample)
);

// File: tb/scl_phase_gen_tb.sv
`timescale 1ns/1ps
module scl_phase_gen_tb;
  localparam int PW = 8;
  localparam int TW = 3;
  localparam int CW = PW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          park = 1'b1;
  logic [PW-1:0] lo_p = 8'd10, hi_p = 8'd10, hold_p = '0;
  logic [CW-1:0] samp_p = '0;
  logic          s_en = 1'b0, d_en = 1'b0;
  logic [TW-1:0] s_thr = '0, d_thr = '0;
  logic          sda_raw = 1'b1;
  logic          stretch = 1'b0;
  logic          drv, scl_f, sda_f, s_fall, s_chg, s_rise, s_samp;
  wire           scl_line = ~(drv | stretch);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  scl_phase_gen #(.PW(PW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .park(park),
    .lo_period(lo_p), .hi_period(hi_p), .hold_pos(hold_p), .sample_pos(samp_p),
    .scl_dg_en(s_en), .scl_dg_thr(s_thr), .sda_dg_en(d_en), .sda_dg_thr(d_thr),
    .scl_in(scl_line), .sda_in(sda_raw),
    .scl_drive_low(drv), .scl_filt(scl_f), .sda_filt(sda_f),
    .stb_fall(s_fall), .stb_change(s_chg), .stb_rise(s_rise), .stb_sample(s_samp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_high(input int h, input bit en, input int t);
    if (!en) return h + 7;
    if (t <= 2) return h + 8;
    return h + 6 + t;
  endfunction

  task automatic setup(input int lo, input int hi, input int hold, input int samp,
                       input bit en, input int thr);
    @(negedge clk);
    park   = 1'b1;
    lo_p   = PW'(lo);
    hi_p   = PW'(hi);
    hold_p = PW'(hold);
    samp_p = CW'(samp);
    s_en   = en;
    s_thr  = TW'(thr);
    repeat (12) @(negedge clk);
    park = 1'b0;
  endtask

  task automatic measure(input int s);
    int lo_n, hi_n, nf, nc, nr, ns, fi, ci, ri, si, hf;
    string hreq;
    while (drv) @(negedge clk);
    while (!drv) @(negedge clk);
    stretch = (s > 0);
    lo_n = 0; nf = 0; nc = 0; fi = -1; ci = -1;
    while (drv) begin
      if (s_fall) begin nf++; fi = lo_n; end
      if (s_chg)  begin nc++; ci = lo_n; end
      lo_n++;
      @(negedge clk);
    end
    hi_n = 0; nr = 0; ns = 0; ri = -1; si = -1; hf = -1;
    while (!drv) begin
      if (s_rise) begin nr++; ri = hi_n; end
      if (s_samp) begin ns++; si = hi_n; end
      if (scl_f && hf < 0) hf = hi_n;
      hi_n++;
      if (stretch && hi_n == s + 1) stretch = 1'b0;
      @(negedge clk);
    end
    hreq = (s > 0) ? "R5" : (!s_en ? "R2" : (int'(s_thr) <= 2 ? "R3" : "R4"));
    chk("R1", "low length", lo_n, int'(lo_p) + 1);
    chk(hreq, "released length", hi_n, exp_high(int'(hi_p), s_en, int'(s_thr)) + s);
    chk("R7", "fall index", fi, 0);
    chk("R7", "fall count", nf, 1);
    chk("R7", "change index", ci, int'(hold_p));
    chk("R7", "change count", nc, 1);
    chk("R8", "rise index", ri, 0);
    chk("R8", "rise count", nr, 1);
    chk("R8", "sample index", si, hf + int'(samp_p));
    chk("R8", "sample count", ns, 1);
  endtask

  task automatic run_cfg(input int lo, input int hi, input int hold, input int samp,
                         input bit en, input int thr, input int s);
    setup(lo, hi, hold, samp, en, thr);
    measure(s);
  endtask

  task automatic pulse(input bit en, input int t, input int w, input bit pol);
    int first, expf;
    @(negedge clk);
    d_en = en;
    d_thr = TW'(t);
    sda_raw = pol;
    repeat (12) @(negedge clk);
    sda_raw = ~pol;
    first = -1;
    for (int k = 1; k <= w + 12; k++) begin
      @(negedge clk);
      if (sda_f == ~pol && first < 0) first = k;
      if (k == w) sda_raw = pol;
    end
    expf = (!en || w > t) ? (en ? t + 1 : 1) : -1;
    chk("R6", "filter flip cycle", first, expf);
  endtask

  initial begin
    int n;
    bit bad;
    void'($urandom(32'd20250));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "drive low in reset", int'(drv), 1);
    chk("R10", "scl filter in reset", int'(scl_f), 1);
    chk("R10", "sda filter in reset", int'(sda_f), 1);
    chk("R9", "strobes while parked", int'({s_fall, s_chg, s_rise, s_samp}), 0);
    rst_n = 1'b1;

    run_cfg(8, 0, 0, 0, 1'b0, 0, 0);
    run_cfg(12, 20, 12, 24, 1'b0, 5, 0);
    for (int t = 0; t < 8; t++) run_cfg(12, 20, 3, 24, 1'b1, t, 0);
    run_cfg(255, 255, 255, 259, 1'b1, 7, 0);
    run_cfg(20, 5, 7, 9, 1'b0, 0, 1);
    run_cfg(20, 5, 7, 0, 1'b1, 6, 25);
    run_cfg(20, 5, 7, 3, 1'b1, 1, 4);

    for (int i = 0; i < 30; i++) begin
      int lo, hi;
      lo = $urandom_range(60, 8);
      hi = $urandom_range(60, 0);
      run_cfg(lo, hi, $urandom_range(lo, 0), $urandom_range(hi + 4, 0),
              1'($urandom_range(1, 0)), $urandom_range(7, 0),
              (i % 3 == 0) ? $urandom_range(12, 1) : 0);
    end

    // R9 park mid-phase
    setup(15, 10, 2, 3, 1'b0, 0);
    measure(0);
    repeat (5) @(negedge clk);
    park = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!drv || s_fall || s_chg || s_rise || s_samp) bad = 1'b1;
    end
    chk("R9", "parked low and quiet", int'(bad), 0);
    park = 1'b0;
    n = 0;
    @(negedge clk);
    while (drv && n < 1000) begin n++; @(negedge clk); end
    chk("R9", "edges to release after unpark", n, 15);
    measure(0);

    // R6 data filter
    pulse(1'b0, 0, 1, 1'b1);
    pulse(1'b0, 3, 1, 1'b0);
    for (int t = 0; t < 8; t++) begin
      if (t > 0) pulse(1'b1, t, t, 1'b1);
      pulse(1'b1, t, t + 1, 1'b1);
      pulse(1'b1, t, t + 1, 1'b0);
    end
    for (int i = 0; i < 6; i++) pulse(1'b1, $urandom_range(7, 0), $urandom_range(10, 1), 1'($urandom_range(1, 0)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule